// File: doc/BRIEF.md
# SPI Master Mode-Fault Guard

This block protects the master/slave control bits of a serial peripheral port. While the port is configured as a master, it watches a slave-select level. That level comes either from the external select pin, after a two-flop synchronizer, or from a level that software holds in the control register. If the level goes low while the port is a master, some other master has claimed the bus. The block then raises a mode-fault flag and, on the same clock edge, drops both the port enable and the master bit. The port therefore stops driving and falls back to slave.

The fault stays pending until software completes a two-step release: first an access to the status register while the flag is set, then any write to the control register. While the flag is pending, control writes can still change the other fields. They cannot set the enable or master bit, and this includes the write that releases the flag. A busy-kill output forces the transfer engine's busy indication low while the fault is pending. An error interrupt follows the flag when it is enabled.

Top module: `spi_mfault_guard`

## Requirements
- R1: After reset, every output is low: enable, master, select mode, select level, interrupt enable, fault, busy-kill and interrupt.
- R2: With no fault pending, a control write loads all five fields on the next edge. The field positions are: bit 0 port enable, bit 1 master, bit 2 software-select mode, bit 3 software-select level, bit 4 error-interrupt enable.
- R3: In master mode with software-select mode set, a select level of 0 raises the fault on the edge after the register holds those values.
- R4: In master mode with software-select mode clear, a low select pin raises the fault on the third rising edge after the pin changes (two synchronizer stages plus the flag register).
- R5: On the edge that raises the fault, both the enable and the master outputs go to 0.
- R6: While the master bit is 0, the fault is never raised, whatever the select pin or the software level.
- R7: The error interrupt is high exactly when the fault is pending and the interrupt-enable field is 1.
- R8: The busy-kill output is high exactly while the fault is pending.
- R9: While the fault is pending, a control write leaves enable and master at 0 but still loads bits 2 to 4.
- R10: The fault is released only by a control write that follows a status access made while the fault was pending. A control write without such an access does not release it. A status access made before the fault existed does not count.
- R11: The control write that releases the fault cannot set enable or master. Both read 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_pin_i | input | 1 | External slave-select pin, asynchronous, active low |
| cr_wr_i | input | 1 | Control-register write strobe |
| cr_wdata_i | input | 5 | Control-register write data |
| sr_acc_i | input | 1 | Status-register read or write strobe |
| enable_o | output | 1 | Port enable |
| master_o | output | 1 | Master mode |
| sel_sw_o | output | 1 | Software-select mode |
| sel_lvl_o | output | 1 | Software-select level |
| irq_en_o | output | 1 | Error-interrupt enable |
| fault_o | output | 1 | Mode-fault flag |
| busy_kill_o | output | 1 | Forces the transfer engine's busy indication low |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The bench writes every one of the 32 control values with no fault pending and predicts from the bits alone whether a fault follows. A detector that ignored the select mode, or that failed to clear enable and master, fails on the first faulting pattern. It writes all 32 values again while a fault is pending. A design that let those writes through, or that dropped the other fields, shows up at once. It checks the pin-to-flag latency edge by edge, because a missing or extra synchronizer stage moves the flag one edge. Finally it exercises the release sequence's traps: a bare control write, a status access made before the fault, and a release write that tries to re-enable the port. Each of these would either release the fault early or return the port to master.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;

  localparam int CTRL_W = 5;

  localparam int B_EN  = 0;
  localparam int B_MST = 1;
  localparam int B_SSW = 2;
  localparam int B_SLV = 3;
  localparam int B_IRQ = 4;

  typedef struct packed {
    logic irq_en;
    logic sel_lvl;
    logic sel_sw;
    logic master;
    logic enable;
  } ctrl_t;

  // Effective select level seen by the detector.
  function automatic logic sel_level(input logic sw_mode, input logic sw_lvl,
                                     input logic pin_sync);
    return sw_mode ? sw_lvl : pin_sync;
  endfunction

  // Fault condition: a master sees its select driven low.
  function automatic logic fault_cond(input logic is_master, input logic lvl);
    return is_master & ~lvl;
  endfunction

  // Control write image with enable/master suppressed while blocked.
  function automatic ctrl_t gate_write(input logic [CTRL_W-1:0] wd,
                                       input logic blocked);
    ctrl_t c;
    c.enable  = wd[B_EN]  & ~blocked;
    c.master  = wd[B_MST] & ~blocked;
    c.sel_sw  = wd[B_SSW];
    c.sel_lvl = wd[B_SLV];
    c.irq_en  = wd[B_IRQ];
    return c;
  endfunction

endpackage

// File: rtl/mf_sync.sv
module mf_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= RESET_VAL;
          else        stg[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RESET_VAL;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mf_detect.sv
module mf_detect
  import spi_mf_pkg::*;
(
  input  logic master_i,
  input  logic sel_sw_i,
  input  logic sel_lvl_i,
  input  logic pin_sync_i,
  output logic sel_low_o,
  output logic raise_o
);
  logic lvl;
  assign lvl       = sel_level(sel_sw_i, sel_lvl_i, pin_sync_i);
  assign sel_low_o = ~lvl;
  assign raise_o   = fault_cond(master_i, lvl);
endmodule

// File: rtl/mf_clear_seq.sv
module mf_clear_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic raise_i,
  input  logic sr_acc_i,
  input  logic cr_wr_i,
  output logic fault_o,
  output logic armed_o,
  output logic clear_o
);
  logic fault_q, armed_q;

  assign clear_o = fault_q & armed_q & cr_wr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (raise_i)      fault_q <= 1'b1;
      else if (clear_o) fault_q <= 1'b0;

      if (clear_o || !fault_q)   armed_q <= 1'b0;
      else if (sr_acc_i)         armed_q <= 1'b1;
    end
  end

  assign fault_o = fault_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/mf_ctrl_reg.sv
module mf_ctrl_reg
  import spi_mf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cr_wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              blocked_i,
  input  logic              raise_i,
  output ctrl_t             ctrl_o
);
  ctrl_t q, nxt;

  always_comb begin
    nxt = q;
    if (cr_wr_i) nxt = gate_write(wdata_i, blocked_i);
    if (raise_i) begin
      nxt.enable = 1'b0;
      nxt.master = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assign ctrl_o = q;
endmodule

// File: rtl/spi_mfault_guard.sv
module spi_mfault_guard #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ss_pin_i,
  input  logic                        cr_wr_i,
  input  logic [spi_mf_pkg::CTRL_W-1:0] cr_wdata_i,
  input  logic                        sr_acc_i,
  output logic                        enable_o,
  output logic                        master_o,
  output logic                        sel_sw_o,
  output logic                        sel_lvl_o,
  output logic                        irq_en_o,
  output logic                        fault_o,
  output logic                        busy_kill_o,
  output logic                        err_irq_o
);
  import spi_mf_pkg::*;

  logic  pin_sync_w, sel_low_w, raise_w, fault_w, armed_w, clear_w;
  ctrl_t ctrl_w;

  mf_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ss_pin_i), .q_o(pin_sync_w)
  );

  mf_detect u_det (
    .master_i(ctrl_w.master), .sel_sw_i(ctrl_w.sel_sw),
    .sel_lvl_i(ctrl_w.sel_lvl), .pin_sync_i(pin_sync_w),
    .sel_low_o(sel_low_w), .raise_o(raise_w)
  );

  mf_clear_seq u_seq (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_w), .sr_acc_i(sr_acc_i),
    .cr_wr_i(cr_wr_i), .fault_o(fault_w), .armed_o(armed_w), .clear_o(clear_w)
  );

  mf_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .cr_wr_i(cr_wr_i), .wdata_i(cr_wdata_i),
    .blocked_i(fault_w), .raise_i(raise_w), .ctrl_o(ctrl_w)
  );

  assign enable_o    = ctrl_w.enable;
  assign master_o    = ctrl_w.master;
  assign sel_sw_o    = ctrl_w.sel_sw;
  assign sel_lvl_o   = ctrl_w.sel_lvl;
  assign irq_en_o    = ctrl_w.irq_en;
  assign fault_o     = fault_w;
  assign busy_kill_o = fault_w;
  assign err_irq_o   = fault_w & ctrl_w.irq_en;
endmodule

// File: rtl/spi_mf_checker.sv
module spi_mf_checker (
  input logic clk,
  input logic rst_n,
  input logic cr_wr,
  input logic enable,
  input logic master,
  input logic fault,
  input logic armed,
  input logic sel_low,
  input logic err_irq,
  input logic busy_kill
);
  assert_raise_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(master && sel_low));

  assert_fault_drops_ctrl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!enable && !master));

  assert_slave_never_faults_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> !$rose(fault));

  assert_irq_needs_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> fault);

  assert_busy_kill_on_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> busy_kill);

  assert_no_enable_in_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> !$past(fault));

  assert_release_sequence_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> $past(cr_wr && armed));
endmodule

bind spi_mfault_guard spi_mf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cr_wr(cr_wr_i), .enable(enable_o),
  .master(master_o), .fault(fault_o), .armed(armed_w), .sel_low(sel_low_w),
  .err_irq(err_irq_o), .busy_kill(busy_kill_o)
);

// File: tb/test_spi_mfault_guard.sv
module test_spi_mfault_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ss_pin = 1'b1;
  logic cr_wr = 1'b0;
  logic [4:0] cr_wdata = '0;
  logic sr_acc = 1'b0;
  logic enable, master, sel_sw, sel_lvl, irq_en, fault, busy_kill, err_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_mfault_guard i_spi_mfault_guard (
    .clk(clk), .rst_n(rst_n), .ss_pin_i(ss_pin), .cr_wr_i(cr_wr),
    .cr_wdata_i(cr_wdata), .sr_acc_i(sr_acc), .enable_o(enable),
    .master_o(master), .sel_sw_o(sel_sw), .sel_lvl_o(sel_lvl),
    .irq_en_o(irq_en), .fault_o(fault), .busy_kill_o(busy_kill),
    .err_irq_o(err_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] v);
    cr_wr = 1'b1; cr_wdata = v;
    tick();
    cr_wr = 1'b0;
  endtask

  task automatic sr();
    sr_acc = 1'b1;
    tick();
    sr_acc = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {err_irq, busy_kill, fault, irq_en, sel_lvl, sel_sw, master, enable};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", outs(), 8'h00);
    rst_n = 1'b1;
    tick();

    // Sweep all control values with no fault pending.
    for (int v = 0; v < 32; v++) begin
      logic [4:0] b;
      logic f;
      b = v[4:0];
      wr(b);
      chk("R2 control load", outs(), {3'b000, b});
      f = b[1] & b[2] & ~b[3];
      tick();
      chk("R3 sw-select fault", {7'd0, fault}, {7'd0, f});
      chk("R5 enable/master drop", {6'd0, master, enable},
          {6'd0, b[1] & ~f, b[0] & ~f});
      chk("R7 irq", {7'd0, err_irq}, {7'd0, f & b[4]});
      chk("R8 busy kill", {7'd0, busy_kill}, {7'd0, f});
      if (!b[1]) chk("R6 slave no fault", {7'd0, fault}, 8'd0);
      if (f) sr();
      wr(5'b00000);
      chk("R10 cleared", {7'd0, fault}, 8'd0);
    end

    // Pin latency in hardware-select mode.
    wr(5'b00011);
    ss_pin = 1'b0;
    tick();
    chk("R4 edge1 no fault", {7'd0, fault}, 8'd0);
    tick();
    chk("R4 edge2 no fault", {7'd0, fault}, 8'd0);
    tick();
    chk("R4 edge3 fault", {7'd0, fault}, 8'd1);
    chk("R5 after pin fault", {6'd0, master, enable}, 8'd0);
    ss_pin = 1'b1;
    sr();
    wr(5'b00000);
    repeat (3) tick();

    // Writes while fault pending.
    wr(5'b00110);
    tick();
    chk("R3 fault for blocking sweep", {7'd0, fault}, 8'd1);
    for (int v = 0; v < 32; v++) begin
      logic [4:0] b;
      b = v[4:0];
      wr(b);
      chk("R9 blocked write", outs(), {b[4], 2'b11, b[4:2], 2'b00});
    end
    chk("R10 bare write keeps fault", {7'd0, fault}, 8'd1);
    sr();
    wr(5'b00011);
    chk("R11 release write fields", outs(), 8'h00);
    wr(5'b00011);
    chk("R2 re-enable after release", {6'd0, master, enable}, 8'd3);
    tick();
    chk("R6 no fault with pin high", {7'd0, fault}, 8'd0);

    // Status access before fault does not arm.
    sr();
    wr(5'b00111);
    tick();
    chk("R3 fault again", {7'd0, fault}, 8'd1);
    wr(5'b00000);
    chk("R10 early status ignored", {7'd0, fault}, 8'd1);
    sr();
    wr(5'b00000);
    chk("R10 proper release", {7'd0, fault}, 8'd0);

    // Slave with pin low and sw level low.
    ss_pin = 1'b0;
    wr(5'b00101);
    repeat (4) tick();
    chk("R6 slave sw low", {7'd0, fault}, 8'd0);
    wr(5'b00001);
    repeat (4) tick();
    chk("R6 slave pin low", {7'd0, fault}, 8'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule